// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of input rows by a fixed 3x3 weight matrix on a square grid of multiply-accumulate cells. Each cell keeps one weight. A single strobe loads all nine weights at once. Each input row then passes through the grid: the element for grid row k is delayed by k cycles, moves rightwards one cell per cycle, and meets the weights of that row. The partial sums move downwards, one cell per cycle. They start from zero at the top and come out of the bottom of each column as one element of the output row.

A caller presents a whole input row in one cycle together with a valid strobe. The block applies the entry skew itself. The results come out skewed: column n reports one cycle after column n-1, and each column has its own valid flag. New rows may be given on every cycle. The weights should be loaded while no row is in flight.

Top module: `wsmm_array`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every `out_valid` bit is low and every `out_y` lane is zero.
- R2: A one-cycle `wt_load` pulse captures all weights. The weight of grid row k, column n sits at bits [(k*COLS+n)*8 +: 8] of `wt_bus`. Every row accepted after the pulse uses these weights until the next pulse. Weights do not change while `wt_load` is low.
- R3: For an input row x (lane k at `in_data[k*8 +: 8]`, signed two's complement) accepted with `in_valid`, column n reports the signed 20-bit value y[n] = sum over k of x[k]*W[k][n] in lane `out_y[n*20 +: 20]`. The value is exact even for extreme operands such as -128.
- R4: If `in_valid` is sampled high at clock edge T, then `out_valid[n]` is high, with its result, directly after edge T+ROWS-1+n. Each accepted row gives exactly one result per column.
- R5: Rows accepted on consecutive cycles give correct results, one per cycle per column, in the order the rows were accepted.
- R6: When `in_valid` is low, `in_data` has no effect. A column whose `out_valid` bit is low shows zero on its `out_y` lane. The cells pass zeros onwards when they hold no valid data.
- R7: `out_valid[n]` equals `out_valid[n-1]` delayed by one cycle, for every n >= 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_load | input | 1 | Strobe that captures the full weight bus |
| wt_bus | input | ROWS*COLS*8 | All weights, packed row-major |
| in_valid | input | 1 | The input row on `in_data` is valid |
| in_data | input | ROWS*8 | One input row, lane k feeds grid row k |
| out_valid | output | COLS | Per-column result valid, skewed by column |
| out_y | output | COLS*20 | Per-column signed result lanes |

## Verification
The multiplier is tested with several kinds of input. A single row against a permutation-like weight matrix shows whether each lane reaches the correct column. All-extreme operands (-128 and 127) expose sign handling and any truncation of the accumulator. Bursts of random rows on consecutive cycles separate correct pipelining from interference between neighbouring rows. Idle cycles with garbage on the data lanes test that invalid data stays out of the results, and a second random weight set shows that a reload takes effect for later rows. Each result is compared with a product computed in the testbench, and its arrival cycle is compared with the expected skewed latency.

// File: rtl/wsmm_pkg.sv
package wsmm_pkg;

    parameter int DATA_W = 8;
    parameter int ACC_W  = 20;

    typedef logic signed [DATA_W-1:0] dat_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // one horizontal lane: operand plus its valid bit
    typedef struct packed {
        logic vld;
        dat_t dat;
    } lane_t;

    // widen first, then multiply, so the product is exact in accumulator width
    function automatic acc_t mac(acc_t ps, dat_t a, dat_t w);
        acc_t wa;
        acc_t ww;
        wa = acc_t'(a);
        ww = acc_t'(w);
        return ps + wa * ww;
    endfunction

endpackage

// File: rtl/wsmm_skew.sv
module wsmm_skew
    import wsmm_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t d,
    output lane_t q
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_dly
            lane_t stg [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end

            assign q = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/wsmm_cell.sv
module wsmm_cell
    import wsmm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wt_load,
    input  dat_t  wt_in,
    input  lane_t a_in,
    input  acc_t  ps_in,
    output lane_t a_out,
    output acc_t  ps_out
);

    dat_t  w_q;
    lane_t a_q;
    acc_t  ps_q;

    always_ff @(posedge clk) begin
        if (rst)          w_q <= '0;
        else if (wt_load) w_q <= wt_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            ps_q <= '0;
        end else if (a_in.vld) begin
            a_q  <= a_in;
            ps_q <= mac(ps_in, a_in.dat, w_q);
        end else begin
            a_q  <= '0;
            ps_q <= '0;
        end
    end

    assign a_out  = a_q;
    assign ps_out = ps_q;

    // R2
    weight_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wt_load |=> $stable(w_q));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !a_in.vld |=> (ps_out == '0 && a_out == '0));

endmodule

// File: rtl/wsmm_array.sv
module wsmm_array
    import wsmm_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wt_load,
    input  logic [ROWS*COLS*DATA_W-1:0] wt_bus,
    input  logic                        in_valid,
    input  logic [ROWS*DATA_W-1:0]      in_data,
    output logic [COLS-1:0]             out_valid,
    output logic [COLS*ACC_W-1:0]       out_y
);

    localparam int NCELL = ROWS * COLS;

    lane_t ent [ROWS];
    lane_t hor [ROWS][COLS+1];
    acc_t  ver [ROWS+1][COLS];

    genvar r, c;
    generate
        for (r = 0; r < ROWS; r++) begin : g_row
            assign ent[r].vld = in_valid;
            assign ent[r].dat = in_data[r*DATA_W +: DATA_W];

            wsmm_skew #(.DEPTH(r)) u_skew (
                .clk (clk),
                .rst (rst),
                .d   (ent[r]),
                .q   (hor[r][0])
            );

            for (c = 0; c < COLS; c++) begin : g_col
                wsmm_cell u_cell (
                    .clk     (clk),
                    .rst     (rst),
                    .wt_load (wt_load),
                    .wt_in   (wt_bus[(r*COLS+c)*DATA_W +: DATA_W]),
                    .a_in    (hor[r][c]),
                    .a_out   (hor[r][c+1]),
                    .ps_in   (ver[r][c]),
                    .ps_out  (ver[r+1][c])
                );
            end

            // R6
            edge_zero_chk: assert property (@(posedge clk) disable iff (rst)
                !hor[r][COLS].vld |-> (hor[r][COLS].dat == '0));

            if (r > 0) begin : g_lat
                // R4
                lat_chain_chk: assert property (@(posedge clk) disable iff (rst)
                    hor[r][1].vld == $past(hor[r-1][1].vld));
            end
        end

        for (c = 0; c < COLS; c++) begin : g_out
            assign ver[0][c] = '0;
            assign out_valid[c] = hor[ROWS-1][c+1].vld;
            assign out_y[c*ACC_W +: ACC_W] = ver[ROWS][c];

            if (c > 0) begin : g_skw
                // R7
                col_skew_chk: assert property (@(posedge clk) disable iff (rst)
                    out_valid[c] == $past(out_valid[c-1]));
            end
        end
    endgenerate

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && out_y == '0));

    initial begin
        // R3
        acc_width_chk: assert (ACC_W >= 2*DATA_W + $clog2(ROWS) && NCELL > 0);
    end

endmodule

// File: tb/wsmm_array_tb_top.sv
module wsmm_array_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wt_load = 1'b0;
    logic [71:0] wt_bus = '0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic [2:0]  out_valid;
    logic [59:0] out_y;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;
    int wm [3][3];

    typedef struct {
        int    val;
        int    at;
        string tag;
    } exp_t;

    exp_t sbq [3][$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wsmm_array dut_i (
        .clk       (clk),
        .rst       (rst),
        .wt_load   (wt_load),
        .wt_bus    (wt_bus),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int rnd8();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic load_w();
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 3; n++)
                wt_bus[(k*3+n)*8 +: 8] = 8'(wm[k][n]);
        wt_load = 1'b1;
        @(negedge clk);
        wt_load = 1'b0;
    endtask

    // driver: pushes expected values with their arrival cycle, then drives the row
    task automatic send_row(input int x0, input int x1, input int x2, input string tag);
        int x [3];
        x[0] = x0; x[1] = x1; x[2] = x2;
        for (int n = 0; n < 3; n++) begin
            exp_t e;
            e.val = 0;
            for (int k = 0; k < 3; k++) e.val += x[k] * wm[k][n];
            e.at  = cyc + 3 + n;
            e.tag = tag;
            sbq[n].push_back(e);
        end
        for (int k = 0; k < 3; k++) in_data[k*8 +: 8] = 8'(x[k]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n, input bit junk);
        for (int i = 0; i < n; i++) begin
            if (junk) in_data = 24'($urandom);
            @(negedge clk);
        end
    endtask

    // monitor: compares every column each cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int n = 0; n < 3; n++) begin
                int act;
                act = int'($signed(out_y[n*20 +: 20]));
                if (out_valid[n]) begin
                    if (sbq[n].size() == 0) begin
                        chk(1'b0, "R4 unexpected valid", 1, 0);
                    end else begin
                        exp_t e;
                        e = sbq[n].pop_front();
                        chk(act == e.val, e.tag, act, e.val);
                        chk(cyc == e.at, "R4 arrival cycle", cyc, e.at);
                    end
                end else begin
                    chk(act == 0, "R6 idle lane zero", act, 0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, while asserted
        chk(out_valid == 3'b000, "R1 valid in reset", int'(out_valid), 0);
        chk(out_y == '0, "R1 y in reset", int'(out_y[19:0]), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 3'b000, "R1 valid after reset", int'(out_valid), 0);

        // R3: single row, distinct weights per lane
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 3; n++) wm[k][n] = (k == n) ? 1 : ((k + 1) % 3 == n ? 10 : 0);
        wm[2][0] = 100;
        load_w();
        send_row(3, 5, 7, "R3 lane routing");
        idle(6, 1'b0);

        // R3: extreme operands
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 3; n++) wm[k][n] = -128;
        wm[0][2] = 127; wm[1][2] = 127; wm[2][2] = 127;
        load_w();
        send_row(-128, -128, -128, "R3 extreme");
        send_row(127, -128, 127, "R3 mixed sign");
        idle(6, 1'b0);

        // R5: back-to-back random rows
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 3; n++) wm[k][n] = rnd8();
        load_w();
        for (int i = 0; i < 8; i++) send_row(rnd8(), rnd8(), rnd8(), "R5 burst");

        // R6: garbage data without valid
        idle(10, 1'b1);
        send_row(rnd8(), rnd8(), rnd8(), "R6 after idle");
        idle(2, 1'b1);
        send_row(rnd8(), rnd8(), rnd8(), "R6 gapped");
        idle(8, 1'b0);

        // R2: reload changes the weights used for later rows
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 3; n++) wm[k][n] = rnd8();
        load_w();
        for (int i = 0; i < 5; i++) send_row(rnd8(), rnd8(), rnd8(), "R2 reloaded");
        idle(3, 1'b1);
        for (int i = 0; i < 4; i++) send_row(rnd8(), rnd8(), rnd8(), "R7 skewed stream");
        idle(10, 1'b0);

        // R4: every accepted row produced a result in every column
        for (int n = 0; n < 3; n++)
            chk(sbq[n].size() == 0, "R4 missing results", sbq[n].size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule